// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block gathers up to 32 interrupt lines into a pending register and reports to the processor core the highest priority level that is allowed through. Each line is configured as level-sensitive, edge-latched or non-maskable. Each priority level has a membership mask that names the lines belonging to it. The core supplies its current interrupt level. The controller searches from the top level downward and stops at the first level that owns at least one eligible line. It reports that level number and raises a request. A non-maskable line ignores the enable register. The masking threshold is clamped so that the non-maskable level can never be shut out.

Software sets and clears pending bits through write-one ports. A hardware set always beats a software clear in the same cycle. A group of timer comparators can each pulse the pending bit of an assigned line. Parameters choose the number of implemented lines, the number of levels, the non-maskable level and the comparator-to-line map. Line inputs whose index is at or above the implemented count have no effect.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line is eligible only when its pending bit is 1 and either its enable bit is 1 or its type is non-maskable. An enabled line with no pending bit, or a pending line with enable 0 that is not non-maskable, causes no request.
- R2: If `cur_lvl` is at or above `NMI_LVL`, the effective threshold becomes `NMI_LVL-1`. A pending non-maskable line at level `NMI_LVL` is therefore always reported, even with its enable bit at 0.
- R3: Levels from `NUM_LVL` down to threshold+1 are searched. The highest level whose mask (`lvl_mask[(L-1)*32 +: 32]` for level L) intersects the eligible lines wins. A level equal to or below the threshold never wins.
- R4: When a level wins, `pend_lvl` equals that level number and `irq_req` is 1. When no level wins, `pend_lvl` is 0 and `irq_req` is 0.
- R5: A line input at 1 sets its pending bit. A line input at 0 clears the pending bit only for level-type lines. Edge-type and non-maskable pending bits stay set. The type field for line i is `line_type[2i+1:2i]`: 0 is level, 1 is edge, 2 is non-maskable, and 3 behaves as edge.
- R6: A 1 in `sw_set` sets that pending bit, and a 1 in `sw_clr` clears it. If a line input or a timer hit sets a bit in the same cycle as `sw_clr` clears it, the bit ends up set.
- R7: Line inputs, `sw_set` bits and enable bits at index `NUM_IRQ` or above change no state and never produce a request.
- R8: A 1 on `tmr_hit[t]` sets the pending bit of the line `TMR_LINES[5t +: 5]`.
- R9: `pend_lvl` and `irq_req` respond two clock edges after a change on the line inputs, `sw_set`, `sw_clr`, `tmr_hit` or the enable write. They respond one edge after a change on `cur_lvl`.
- R10: While `rst_n` is 0, the pending and enable registers are cleared, `pend_lvl` is 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Raw interrupt lines, active high |
| line_type | input | 64 | Two-bit type per line (level, edge, non-maskable) |
| en_we | input | 1 | Loads the enable register from `en_wdata` |
| en_wdata | input | 32 | New enable register value |
| sw_set | input | 32 | Write-one-to-set pending bits |
| sw_clr | input | 32 | Write-one-to-clear pending bits |
| lvl_mask | input | NUM_LVL*32 | Per-level line membership masks, level 1 in the low word |
| cur_lvl | input | LVL_W | Current interrupt level of the core |
| tmr_hit | input | NUM_TMR | Timer comparator match pulses |
| pend_lvl | output | LVL_W | Winning level number, 0 when none |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
Any stimulus that reaches the pending or enable register is captured at the first clock edge. It appears on `pend_lvl` and `irq_req` at the second edge. A change on `cur_lvl` appears at the first edge. Every directed scenario drives inputs just after a rising edge and waits a counted number of edges before it samples. The sample is taken one nanosecond after the edge. One scenario samples at both the first and the second edge to pin the two-cycle latency exactly, and another samples one edge after a `cur_lvl` change. Single-cycle pulses on `sw_clr`, `sw_set` and `tmr_hit` are released after one edge, so each check sees the effect of exactly one pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int MAX_LINES = 32;
    localparam int LINE_W    = $clog2(MAX_LINES);

    typedef enum logic [1:0] {
        LK_LEVEL = 2'd0,
        LK_EDGE  = 2'd1,
        LK_NMI   = 2'd2,
        LK_RSVD  = 2'd3
    } line_kind_e;

    typedef struct packed {
        logic [MAX_LINES-1:0] pend;
        logic [MAX_LINES-1:0] en;
    } src_state_t;

endpackage

// File: rtl/irqc_kind_decode.sv
module irqc_kind_decode
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 24
) (
    input  logic [2*MAX_LINES-1:0] line_type,
    output logic [MAX_LINES-1:0]   level_mask,
    output logic [MAX_LINES-1:0]   nmi_mask
);

    for (genvar g = 0; g < MAX_LINES; g++) begin : g_line
        line_kind_e kind;
        assign kind = line_kind_e'(line_type[2*g +: 2]);
        if (g < NUM_IRQ) begin : g_live
            assign level_mask[g] = (kind == LK_LEVEL);
            assign nmi_mask[g]   = (kind == LK_NMI);
        end else begin : g_dead
            assign level_mask[g] = 1'b0;
            assign nmi_mask[g]   = 1'b0;
        end
    end

endmodule

// File: rtl/irqc_timer_map.sv
module irqc_timer_map
    import irqc_pkg::*;
#(
    parameter int                      NUM_TMR   = 3,
    parameter logic [NUM_TMR*LINE_W-1:0] TMR_LINES = '0
) (
    input  logic [NUM_TMR-1:0]   tmr_hit,
    output logic [MAX_LINES-1:0] tmr_set
);

    logic [MAX_LINES-1:0] hit_vec [NUM_TMR];

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam logic [LINE_W-1:0] TGT = TMR_LINES[t*LINE_W +: LINE_W];
        assign hit_vec[t] = tmr_hit[t] ? (MAX_LINES'(1) << TGT) : '0;
    end

    always_comb begin
        tmr_set = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            tmr_set = tmr_set | hit_vec[t];
        end
    end

endmodule

// File: rtl/irqc_src_regs.sv
module irqc_src_regs
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_LINES-1:0] irq_in,
    input  logic [MAX_LINES-1:0] level_mask,
    input  logic [MAX_LINES-1:0] tmr_set,
    input  logic [MAX_LINES-1:0] sw_set,
    input  logic [MAX_LINES-1:0] sw_clr,
    input  logic                 en_we,
    input  logic [MAX_LINES-1:0] en_wdata,
    output logic [MAX_LINES-1:0] pend_q,
    output logic [MAX_LINES-1:0] en_q
);

    localparam logic [MAX_LINES-1:0] LIVE =
        (NUM_IRQ >= MAX_LINES) ? '1 : ((MAX_LINES'(1) << NUM_IRQ) - MAX_LINES'(1));

    src_state_t st_d, st_q;
    logic [MAX_LINES-1:0] hw_set, drop;

    always_comb begin
        hw_set  = irq_in | tmr_set;
        drop    = level_mask & ~irq_in;
        st_d    = st_q;
        st_d.pend = ((st_q.pend & ~sw_clr & ~drop) | sw_set | hw_set) & LIVE;
        if (en_we) begin
            st_d.en = en_wdata & LIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign en_q   = st_q.en;

    // R5
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(irq_in & LIVE)) == $past(irq_in & LIVE)));

    // R5
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(level_mask) & ~$past(sw_clr)) & ~pend_q) == '0));

    // R6
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(sw_clr & ~sw_set & ~irq_in & ~tmr_set)) == '0));

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
    import irqc_pkg::*;
#(
    parameter int NUM_LVL = 7,
    parameter int NMI_LVL = 7,
    parameter int LVL_W   = 3
) (
    input  logic [MAX_LINES-1:0]         pend,
    input  logic [MAX_LINES-1:0]         en,
    input  logic [MAX_LINES-1:0]         nmi_mask,
    input  logic [NUM_LVL*MAX_LINES-1:0] lvl_mask,
    input  logic [LVL_W-1:0]             cur_lvl,
    output logic [LVL_W-1:0]             win_lvl
);

    logic [MAX_LINES-1:0] elig;
    logic [LVL_W-1:0]     thr;
    logic [NUM_LVL:1]     hit;

    always_comb begin
        elig = pend & (en | nmi_mask);
        if (32'(cur_lvl) >= NMI_LVL) begin
            thr = LVL_W'(NMI_LVL - 1);
        end else begin
            thr = cur_lvl;
        end
    end

    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
        assign hit[l] = (LVL_W'(l) > thr) &&
                        (|(lvl_mask[(l-1)*MAX_LINES +: MAX_LINES] & elig));
    end

    always_comb begin
        win_lvl = '0;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (hit[l]) begin
                win_lvl = LVL_W'(l);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 24,
    parameter int NUM_LVL = 7,
    parameter int NMI_LVL = 7,
    parameter int NUM_TMR = 3,
    parameter logic [NUM_TMR*LINE_W-1:0] TMR_LINES = {5'd10, 5'd7, 5'd6},
    localparam int LVL_W = $clog2(NUM_LVL + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [MAX_LINES-1:0]         irq_in,
    input  logic [2*MAX_LINES-1:0]       line_type,
    input  logic                         en_we,
    input  logic [MAX_LINES-1:0]         en_wdata,
    input  logic [MAX_LINES-1:0]         sw_set,
    input  logic [MAX_LINES-1:0]         sw_clr,
    input  logic [NUM_LVL*MAX_LINES-1:0] lvl_mask,
    input  logic [LVL_W-1:0]             cur_lvl,
    input  logic [NUM_TMR-1:0]           tmr_hit,
    output logic [LVL_W-1:0]             pend_lvl,
    output logic                         irq_req
);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             req;
    } out_state_t;

    logic [MAX_LINES-1:0] level_mask, nmi_mask, tmr_set, pend_q, en_q;
    logic [LVL_W-1:0]     win_lvl;
    out_state_t           out_d, out_q;

    irqc_kind_decode #(.NUM_IRQ(NUM_IRQ)) u_decode (
        .line_type (line_type),
        .level_mask(level_mask),
        .nmi_mask  (nmi_mask)
    );

    irqc_timer_map #(.NUM_TMR(NUM_TMR), .TMR_LINES(TMR_LINES)) u_tmap (
        .tmr_hit(tmr_hit),
        .tmr_set(tmr_set)
    );

    irqc_src_regs #(.NUM_IRQ(NUM_IRQ)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .level_mask(level_mask),
        .tmr_set   (tmr_set),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .pend_q    (pend_q),
        .en_q      (en_q)
    );

    irqc_resolver #(.NUM_LVL(NUM_LVL), .NMI_LVL(NMI_LVL), .LVL_W(LVL_W)) u_res (
        .pend    (pend_q),
        .en      (en_q),
        .nmi_mask(nmi_mask),
        .lvl_mask(lvl_mask),
        .cur_lvl (cur_lvl),
        .win_lvl (win_lvl)
    );

    always_comb begin
        out_d     = out_q;
        out_d.lvl = win_lvl;
        out_d.req = (win_lvl != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pend_lvl = out_q.lvl;
    assign irq_req  = out_q.req;

    logic nmi_hit;
    assign nmi_hit = |(lvl_mask[(NMI_LVL-1)*MAX_LINES +: MAX_LINES] & pend_q & nmi_mask);

    // R1
    eligible_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(|(pend_q & (en_q | nmi_mask))));

    // R2
    nmi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_hit |=> (irq_req && (32'(pend_lvl) >= NMI_LVL)));

    // R3
    above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((32'($past(cur_lvl)) >= NMI_LVL) ? (32'(pend_lvl) >= NMI_LVL)
                                                      : (pend_lvl > $past(cur_lvl))));

    // R4
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (32'(pend_lvl) <= NUM_LVL));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

    localparam int LVL_W = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in, en_wdata, sw_set, sw_clr;
    logic [63:0] line_type;
    logic        en_we;
    logic [7*32-1:0] lvl_mask;
    logic [LVL_W-1:0] cur_lvl;
    logic [2:0]  tmr_hit;
    logic [LVL_W-1:0] pend_lvl;
    logic        irq_req;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_type(line_type),
        .en_we(en_we), .en_wdata(en_wdata), .sw_set(sw_set), .sw_clr(sw_clr),
        .lvl_mask(lvl_mask), .cur_lvl(cur_lvl), .tmr_hit(tmr_hit),
        .pend_lvl(pend_lvl), .irq_req(irq_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input int lvl, input bit rq);
        n_run++;
        if (int'(pend_lvl) != lvl || irq_req != rq) begin
            n_fail++;
            $display("FAIL %s: pend_lvl=%0d irq_req=%0b expected pend_lvl=%0d irq_req=%0b",
                     req, pend_lvl, irq_req, lvl, rq);
        end
    endtask

    task automatic write_en(input logic [31:0] v);
        en_we = 1'b1; en_wdata = v;
        tick(1);
        en_we = 1'b0;
    endtask

    task automatic pulse_clr(input logic [31:0] v);
        sw_clr = v;
        tick(1);
        sw_clr = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        tick(3);
        expect_out("R10 in reset", 0, 0);
        rst_n = 1'b1;
        tick(2);
        expect_out("R10 after reset", 0, 0);
    endtask

    task automatic t_basic;
        write_en(32'h2);
        irq_in = 32'h2;
        tick(2);
        expect_out("R4 level1 line", 1, 1);
        irq_in = '0;
        tick(2);
        expect_out("R5 level line drops", 0, 0);
    endtask

    task automatic t_enable;
        write_en(32'h0);
        irq_in = 32'h4;
        tick(2);
        expect_out("R1 disabled line", 0, 0);
        write_en(32'h4);
        tick(1);
        expect_out("R1 enabled line", 1, 1);
        irq_in = '0;
        tick(2);
    endtask

    task automatic t_prio;
        write_en(32'hFFFF_FFFF);
        irq_in = (32'h1 << 2) | (32'h1 << 17);
        tick(2);
        expect_out("R3 highest of 1 and 5", 5, 1);
        cur_lvl = 3'd5;
        tick(1);
        expect_out("R9 cur_lvl one edge, R3 at threshold", 0, 0);
        cur_lvl = 3'd4;
        tick(1);
        expect_out("R3 above threshold", 5, 1);
        cur_lvl = 3'd0;
        irq_in = '0;
        tick(2);
        expect_out("R4 idle", 0, 0);
    endtask

    task automatic t_edge;
        irq_in = 32'h10;
        tick(1);
        irq_in = '0;
        tick(2);
        expect_out("R5 edge line held", 2, 1);
        pulse_clr(32'h10);
        tick(1);
        expect_out("R6 sw clear", 0, 0);
    endtask

    task automatic t_collide;
        irq_in = 32'h20; sw_clr = 32'h20;
        tick(1);
        irq_in = '0; sw_clr = '0;
        tick(1);
        expect_out("R6 hw set beats clear", 2, 1);
        pulse_clr(32'h20);
        tick(1);
        expect_out("R6 cleared later", 0, 0);
    endtask

    task automatic t_swset;
        sw_set = 32'h200;
        tick(1);
        sw_set = '0;
        tick(1);
        expect_out("R6 sw set line 9", 3, 1);
        pulse_clr(32'h200);
        tick(1);
        expect_out("R6 sw set cleared", 0, 0);
    endtask

    task automatic t_nmi;
        write_en(32'h0010_0000);
        irq_in = 32'h0010_0000;
        cur_lvl = 3'd6;
        tick(2);
        expect_out("R3 level equal to cur_lvl blocked", 0, 0);
        cur_lvl = 3'd7;
        irq_in = 32'h0090_0000;
        tick(1);
        irq_in = 32'h0010_0000;
        tick(1);
        expect_out("R2 non-maskable through clamp", 7, 1);
        irq_in = '0;
        tick(2);
        expect_out("R5 non-maskable held", 7, 1);
        pulse_clr(32'h0080_0000);
        cur_lvl = 3'd0;
        tick(1);
        expect_out("R6 non-maskable cleared", 0, 0);
    endtask

    task automatic t_ignore;
        write_en(32'hFFFF_FFFF);
        irq_in = 32'h4000_0000; sw_set = 32'h8000_0000;
        tick(1);
        sw_set = '0;
        tick(1);
        expect_out("R7 high lines ignored", 0, 0);
        irq_in = '0;
        tick(2);
        expect_out("R7 still idle", 0, 0);
    endtask

    task automatic t_timer;
        tmr_hit = 3'b100;
        tick(1);
        tmr_hit = '0;
        tick(1);
        expect_out("R8 comparator 2 to line 10", 3, 1);
        pulse_clr(32'h400);
        tick(1);
        expect_out("R8 cleared", 0, 0);
        tmr_hit = 3'b001;
        tick(1);
        tmr_hit = '0;
        tick(1);
        expect_out("R8 comparator 0 to line 6", 2, 1);
        pulse_clr(32'h40);
        tick(1);
    endtask

    task automatic t_latency;
        irq_in = 32'h2;
        tick(1);
        expect_out("R9 not yet after one edge", 0, 0);
        tick(1);
        expect_out("R9 due after two edges", 1, 1);
        irq_in = '0;
        tick(2);
    endtask

    initial begin : watchdog
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; en_we = 1'b0; en_wdata = '0;
        sw_set = '0; sw_clr = '0; cur_lvl = '0; tmr_hit = '0;
        line_type = '0;
        for (int i = 4; i <= 11; i++) line_type[2*i +: 2] = 2'd1;
        line_type[2*23 +: 2] = 2'd2;
        lvl_mask = {32'h0080_0000, 32'h0070_0000, 32'h000F_0000, 32'h0000_F000,
                    32'hC000_0F00, 32'h0000_00F0, 32'h0000_000F};
        t_reset();
        t_basic();
        t_enable();
        t_prio();
        t_edge();
        t_collide();
        t_swset();
        t_nmi();
        t_ignore();
        t_timer();
        t_latency();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule